// File: doc/BRIEF.md
# Sync Reference Measurement Unit

This unit watches three sync inputs (line, frame and field) that arrive on a fixed 27 MHz sample clock. It works out for itself which level of each input is the active pulse. It then turns each input into a one-cycle strobe on the active-going edge, so every later count starts from the same point whatever the polarity.

From those strobes it measures:
- the line period in clocks, both single and summed over sixteen lines;
- the frame length in lines, over one frame and over two frames;
- the field length in lines;
- the frame period in clocks.

Line and frame periods are compared with fixed time windows. A reference-lost output falls only while both line and frame timing are acceptable. A host reads the results through a small registered read port. All thresholds and widths are parameters, so the same code can run with short windows in a test environment.

Top module: `sync_ref_meas`

## Requirements
- R1: Polarity of each input is judged at each active-high-going transition (rising edge) by comparing the high-cycle count and the low-cycle count of the period that just ended; a high count not greater than the low count means active-high. The stored polarity changes only when two successive judgements agree. Polarity bits in the status word (address 0): bit 3 line, bit 4 frame, bit 5 field; 1 = active high; reset value 0.
- R2: All timing is taken from the leading edge: the rising edge for an active-high input and the falling edge for an active-low one.
- R3: Address 1 holds the clock count between the two most recent line leading edges.
- R4: Address 2 holds the clock count spanning 16 complete line periods, refreshed every 16th line edge.
- R5: Address 3 holds the number of line edges after one frame leading edge up to and including the next one. Address 4 holds the same count across two frame periods.
- R6: Address 5 holds the number of line edges in one field period, counted the same way.
- R7: Address 6 holds the clock count between the two most recent frame leading edges.
- R8: Line timing is valid (status bit 0) only when the last line period lies within H_MIN..H_MAX clocks (243..1890 by default).
- R9: Frame timing is valid (status bit 1) only when the last frame period lies within V_MIN..V_MAX clocks (216000..1350000 by default).
- R10: refLost is low exactly when status bits 0 and 1 are both set. The field input never affects validity. After reset, refLost is high and the status word reads 0.
- R11: Every counter saturates at its all-ones value. Clock counters are the smallest width that holds max+1, and line counters are LINE_W bits wide. When no edge arrives within the maximum period, that signal's valid bit clears.
- R12: A result register changes only on the leading edge that closes its measurement window. Otherwise it holds its value.
- R13: rdData shows the register at the address presented one clock earlier. Address 7 and unused status bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsIn | input | 1 | Line sync input |
| vsIn | input | 1 | Frame sync input |
| fsIn | input | 1 | Field sync input |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Read data, one cycle after the address |
| refLost | output | 1 | High while line or frame timing is invalid |

## Verification
The assertions assume that the sync inputs change only between clock edges, as signals already sampled into the clock domain. They also assume that a validity bit can only be set by a leading-edge strobe from the polarity stage.

The bench drives each input from an ideal pulse generator with whole-clock periods and pulse widths. Polarity changes come in phases that last many periods, so every measurement window closes cleanly before the expected values are read back. The bench also holds inputs idle and uses periods outside the windows to reach the saturation and missing-edge cases.

// File: rtl/sync_ref_meas_pkg.sv
package sync_ref_meas_pkg;

  typedef struct packed {
    logic hLead;
    logic vLead;
    logic fLead;
  } strobe_t;

  typedef enum logic [2:0] {
    ADDR_STATUS = 3'd0,
    ADDR_HPER   = 3'd1,
    ADDR_H16    = 3'd2,
    ADDR_VLINES = 3'd3,
    ADDR_V2     = 3'd4,
    ADDR_FLINES = 3'd5,
    ADDR_VCLK   = 3'd6
  } reg_addr_e;

  localparam int STAT_HOK  = 0;
  localparam int STAT_VOK  = 1;
  localparam int STAT_HPOL = 3;
  localparam int STAT_VPOL = 4;
  localparam int STAT_FPOL = 5;

endpackage

// File: rtl/sync_ref_meas_pol.sv
module sync_ref_meas_pol #(
  parameter int CW = 21
) (
  input  logic clk,
  input  logic rstN,
  input  logic sIn,
  output logic lead,
  output logic activeHigh
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          sQ, sD;
  logic [CW-1:0] hiCnt, loCnt;
  logic          seen, candOk, lastCand;
  logic          rise, fall, cand;

  assign rise = sQ & ~sD;
  assign fall = ~sQ & sD;
  // short high phase -> active-high pulse
  assign cand = (hiCnt <= loCnt);
  assign lead = activeHigh ? rise : fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sQ         <= 1'b0;
      sD         <= 1'b0;
      hiCnt      <= '0;
      loCnt      <= '0;
      seen       <= 1'b0;
      candOk     <= 1'b0;
      lastCand   <= 1'b0;
      activeHigh <= 1'b0;
    end else begin
      sD <= sQ;
      sQ <= sIn;
      if (rise) begin
        hiCnt <= CW'(1);
        loCnt <= '0;
        seen  <= 1'b1;
        if (seen) begin
          candOk   <= 1'b1;
          lastCand <= cand;
          if (candOk && (cand == lastCand)) activeHigh <= cand;
        end
      end else if (sQ) begin
        if (hiCnt != CMAX) hiCnt <= hiCnt + CW'(1);
      end else begin
        if (loCnt != CMAX) loCnt <= loCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_ref_meas_ctrl.sv
module sync_ref_meas_ctrl
  import sync_ref_meas_pkg::*;
#(
  parameter int CW = 21
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsIn,
  input  logic       vsIn,
  input  logic       fsIn,
  output strobe_t    stb,
  output logic [2:0] polHigh
);
  localparam int NCH = 3;

  logic [NCH-1:0] rawIn;
  logic [NCH-1:0] leadVec;

  assign rawIn = {fsIn, vsIn, hsIn};

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    sync_ref_meas_pol #(.CW(CW)) u_pol (
      .clk       (clk),
      .rstN      (rstN),
      .sIn       (rawIn[i]),
      .lead      (leadVec[i]),
      .activeHigh(polHigh[i])
    );
  end

  assign stb.hLead = leadVec[0];
  assign stb.vLead = leadVec[1];
  assign stb.fLead = leadVec[2];
endmodule

// File: rtl/sync_ref_meas_dp.sv
module sync_ref_meas_dp
  import sync_ref_meas_pkg::*;
#(
  parameter int H_MIN  = 243,
  parameter int H_MAX  = 1890,
  parameter int V_MIN  = 216000,
  parameter int V_MAX  = 1350000,
  parameter int H_AVG  = 16,
  parameter int LINE_W = 12,
  parameter int HCW    = 11,
  parameter int H16W   = 15,
  parameter int VCW    = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [HCW-1:0]    hPeriod,
  output logic [H16W-1:0]   h16Period,
  output logic [LINE_W-1:0] vLines,
  output logic [LINE_W-1:0] v2Lines,
  output logic [LINE_W-1:0] fLines,
  output logic [VCW-1:0]    vPeriod,
  output logic              hOk,
  output logic              vOk
);
  localparam int IDXW = (H_AVG > 1) ? $clog2(H_AVG) : 1;
  localparam logic [HCW-1:0]    H_LO   = HCW'(H_MIN);
  localparam logic [HCW-1:0]    H_HI   = HCW'(H_MAX);
  localparam logic [VCW-1:0]    V_LO   = VCW'(V_MIN);
  localparam logic [VCW-1:0]    V_HI   = VCW'(V_MAX);
  localparam logic [HCW-1:0]    HSAT   = '1;
  localparam logic [H16W-1:0]   H16SAT = '1;
  localparam logic [VCW-1:0]    VSAT   = '1;
  localparam logic [IDXW-1:0]   IDXEND = IDXW'(H_AVG - 1);

  function automatic logic [LINE_W-1:0] lineAdd(input logic [LINE_W-1:0] c, input logic inc);
    return (inc && (c != {LINE_W{1'b1}})) ? c + LINE_W'(1) : c;
  endfunction

  logic [HCW-1:0]    hCnt;
  logic [H16W-1:0]   h16Cnt;
  logic [IDXW-1:0]   hIdx;
  logic              hSeen;
  logic [VCW-1:0]    vCnt;
  logic              vSeen, vHalf;
  logic [LINE_W-1:0] vLineCnt, v2Cnt;
  logic              fSeen;
  logic [LINE_W-1:0] fLineCnt;

  // line clock counting, 16-line sum, line validity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt      <= '0;
      h16Cnt    <= '0;
      hIdx      <= '0;
      hSeen     <= 1'b0;
      hPeriod   <= '0;
      h16Period <= '0;
      hOk       <= 1'b0;
    end else if (stb.hLead) begin
      hCnt  <= HCW'(1);
      hSeen <= 1'b1;
      if (hSeen) begin
        hPeriod <= hCnt;
        hOk     <= (hCnt >= H_LO) && (hCnt <= H_HI);
        if (hIdx == IDXEND) begin
          h16Period <= h16Cnt;
          h16Cnt    <= H16W'(1);
          hIdx      <= '0;
        end else begin
          hIdx <= hIdx + IDXW'(1);
          if (h16Cnt != H16SAT) h16Cnt <= h16Cnt + H16W'(1);
        end
      end else begin
        h16Cnt <= H16W'(1);
        hIdx   <= '0;
      end
    end else begin
      if (hCnt > H_HI) hOk <= 1'b0;
      if (hCnt != HSAT) hCnt <= hCnt + HCW'(1);
      if (h16Cnt != H16SAT) h16Cnt <= h16Cnt + H16W'(1);
    end
  end

  // frame clock counting and frame validity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCnt    <= '0;
      vSeen   <= 1'b0;
      vPeriod <= '0;
      vOk     <= 1'b0;
    end else if (stb.vLead) begin
      vCnt  <= VCW'(1);
      vSeen <= 1'b1;
      if (vSeen) begin
        vPeriod <= vCnt;
        vOk     <= (vCnt >= V_LO) && (vCnt <= V_HI);
      end
    end else begin
      if (vCnt > V_HI) vOk <= 1'b0;
      if (vCnt != VSAT) vCnt <= vCnt + VCW'(1);
    end
  end

  // lines per frame, per two frames
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vLineCnt <= '0;
      v2Cnt    <= '0;
      vHalf    <= 1'b0;
      vLines   <= '0;
      v2Lines  <= '0;
    end else if (stb.vLead) begin
      vLineCnt <= '0;
      if (vSeen) vLines <= lineAdd(vLineCnt, stb.hLead);
      if (!vSeen) begin
        v2Cnt <= '0;
        vHalf <= 1'b0;
      end else if (vHalf) begin
        v2Lines <= lineAdd(v2Cnt, stb.hLead);
        v2Cnt   <= '0;
        vHalf   <= 1'b0;
      end else begin
        v2Cnt <= lineAdd(v2Cnt, stb.hLead);
        vHalf <= 1'b1;
      end
    end else begin
      vLineCnt <= lineAdd(vLineCnt, stb.hLead);
      v2Cnt    <= lineAdd(v2Cnt, stb.hLead);
    end
  end

  // lines per field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fLineCnt <= '0;
      fSeen    <= 1'b0;
      fLines   <= '0;
    end else if (stb.fLead) begin
      fLineCnt <= '0;
      fSeen    <= 1'b1;
      if (fSeen) fLines <= lineAdd(fLineCnt, stb.hLead);
    end else begin
      fLineCnt <= lineAdd(fLineCnt, stb.hLead);
    end
  end
endmodule

// File: rtl/sync_ref_meas.sv
module sync_ref_meas
  import sync_ref_meas_pkg::*;
#(
  parameter int H_MIN  = 243,
  parameter int H_MAX  = 1890,
  parameter int V_MIN  = 216000,
  parameter int V_MAX  = 1350000,
  parameter int H_AVG  = 16,
  parameter int LINE_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              fsIn,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              refLost
);
  localparam int HCW  = $clog2(H_MAX + 2);
  localparam int H16W = $clog2(H_AVG * (H_MAX + 1) + 1);
  localparam int VCW  = $clog2(V_MAX + 2);
  localparam int PCW  = VCW;

  strobe_t           stb;
  logic [2:0]        polHigh;
  logic [HCW-1:0]    hPeriod;
  logic [H16W-1:0]   h16Period;
  logic [LINE_W-1:0] vLines, v2Lines, fLines;
  logic [VCW-1:0]    vPeriod;
  logic              hOk, vOk;
  logic [DATA_W-1:0] statusWord, rdNext;

  sync_ref_meas_ctrl #(.CW(PCW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hsIn   (hsIn),
    .vsIn   (vsIn),
    .fsIn   (fsIn),
    .stb    (stb),
    .polHigh(polHigh)
  );

  sync_ref_meas_dp #(
    .H_MIN(H_MIN), .H_MAX(H_MAX), .V_MIN(V_MIN), .V_MAX(V_MAX),
    .H_AVG(H_AVG), .LINE_W(LINE_W), .HCW(HCW), .H16W(H16W), .VCW(VCW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hPeriod  (hPeriod),
    .h16Period(h16Period),
    .vLines   (vLines),
    .v2Lines  (v2Lines),
    .fLines   (fLines),
    .vPeriod  (vPeriod),
    .hOk      (hOk),
    .vOk      (vOk)
  );

  always_comb begin
    statusWord            = '0;
    statusWord[STAT_HOK]  = hOk;
    statusWord[STAT_VOK]  = vOk;
    statusWord[STAT_HPOL] = polHigh[0];
    statusWord[STAT_VPOL] = polHigh[1];
    statusWord[STAT_FPOL] = polHigh[2];
  end

  always_comb begin
    case (rdAddr)
      ADDR_STATUS: rdNext = statusWord;
      ADDR_HPER:   rdNext = DATA_W'(hPeriod);
      ADDR_H16:    rdNext = DATA_W'(h16Period);
      ADDR_VLINES: rdNext = DATA_W'(vLines);
      ADDR_V2:     rdNext = DATA_W'(v2Lines);
      ADDR_FLINES: rdNext = DATA_W'(fLines);
      ADDR_VCLK:   rdNext = DATA_W'(vPeriod);
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign refLost = ~(hOk & vOk);
endmodule

// File: rtl/sync_ref_meas_chk.sv
module sync_ref_meas_chk
  import sync_ref_meas_pkg::*;
#(
  parameter int H_MIN  = 243,
  parameter int H_MAX  = 1890,
  parameter int HCW    = 11,
  parameter int LINE_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           stb,
  input logic              hOk,
  input logic              vOk,
  input logic [HCW-1:0]    hPeriod,
  input logic [LINE_W-1:0] vLines,
  input logic [2:0]        rdAddr,
  input logic [DATA_W-1:0] rdData
);
  // R8: line validity can only appear right after a line leading edge
  a_r8_hok_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hOk) |-> $past(stb.hLead));

  // R8: while valid, the stored line period sits inside the window
  a_r8_hok_in_window: assert property (@(posedge clk) disable iff (!rstN)
    hOk |-> ((hPeriod >= HCW'(H_MIN)) && (hPeriod <= HCW'(H_MAX))));

  // R9: frame validity can only appear right after a frame leading edge
  a_r9_vok_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vOk) |-> $past(stb.vLead));

  // R12: line period register holds between line edges
  a_r12_hperiod_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.hLead |=> $stable(hPeriod));

  // R12: lines-per-frame register holds between frame edges
  a_r12_vlines_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.vLead |=> $stable(vLines));

  // R13: unmapped address reads zero on the next cycle
  a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 3'd7) |=> (rdData == '0));
endmodule

bind sync_ref_meas sync_ref_meas_chk #(
  .H_MIN(H_MIN), .H_MAX(H_MAX), .HCW(HCW), .LINE_W(LINE_W), .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .stb    (stb),
  .hOk    (hOk),
  .vOk    (vOk),
  .hPeriod(hPeriod),
  .vLines (vLines),
  .rdAddr (rdAddr),
  .rdData (rdData)
);

// File: tb/sync_ref_meas_tb.sv
module sync_ref_meas_tb;
  localparam int H_MIN = 20, H_MAX = 60, V_MIN = 600, V_MAX = 3000;
  localparam int H_AVG = 16, LINE_W = 8, DATA_W = 32;
  localparam int HSAT   = (1 << $clog2(H_MAX + 2)) - 1;
  localparam int H16SAT = (1 << $clog2(H_AVG * (H_MAX + 1) + 1)) - 1;
  localparam int VSAT   = (1 << $clog2(V_MAX + 2)) - 1;
  localparam int PSAT   = VSAT;
  localparam int LSAT   = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsIn = 1'b1, vsIn = 1'b1, fsIn = 1'b1;
  logic [2:0] rdAddr = 3'd0;
  logic [DATA_W-1:0] rdData;
  logic refLost;

  always #2 clk = ~clk;

  sync_ref_meas #(
    .H_MIN(H_MIN), .H_MAX(H_MAX), .V_MIN(V_MIN), .V_MAX(V_MAX),
    .H_AVG(H_AVG), .LINE_W(LINE_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .fsIn(fsIn),
    .rdAddr(rdAddr), .rdData(rdData), .refLost(refLost)
  );

  int nChecks = 0, nErr = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int mq[3], md[3], mpol[3], mhi[3], mlo[3], mseen[3], mcok[3], mlast[3];
  int hCnt, h16Cnt, hIdx, hSeen, hPer, h16Per, hOk;
  int vCnt, vSeen, vPer, vOk, vLc, v2c, vHalf, vLin, v2Lin;
  int fSeen, fLc, fLin;
  longint expRd;

  function automatic int sat(input int v, input int m);
    return (v > m) ? m : v;
  endfunction

  function automatic longint regVal(input int a);
    case (a)
      0: return hOk | (vOk << 1) | (mpol[0] << 3) | (mpol[1] << 4) | (mpol[2] << 5);
      1: return hPer;
      2: return h16Per;
      3: return vLin;
      4: return v2Lin;
      5: return fLin;
      6: return vPer;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 3; c++) begin
      mq[c] = 0; md[c] = 0; mpol[c] = 0; mhi[c] = 0; mlo[c] = 0;
      mseen[c] = 0; mcok[c] = 0; mlast[c] = 0;
    end
    hCnt = 0; h16Cnt = 0; hIdx = 0; hSeen = 0; hPer = 0; h16Per = 0; hOk = 0;
    vCnt = 0; vSeen = 0; vPer = 0; vOk = 0; vLc = 0; v2c = 0; vHalf = 0; vLin = 0; v2Lin = 0;
    fSeen = 0; fLc = 0; fLin = 0; expRd = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int lead[3];
      int ins[3];
      int hl, vl, fl;
      ins[0] = hsIn; ins[1] = vsIn; ins[2] = fsIn;
      for (int c = 0; c < 3; c++) begin
        int rs, fa;
        rs = mq[c] && !md[c];
        fa = !mq[c] && md[c];
        lead[c] = mpol[c] ? rs : fa;
      end
      hl = lead[0]; vl = lead[1]; fl = lead[2];
      expRd = regVal(rdAddr);
      for (int c = 0; c < 3; c++) begin
        int cand;
        cand = (mhi[c] <= mlo[c]);
        if (mq[c] && !md[c]) begin
          if (mseen[c]) begin
            if (mcok[c] && cand == mlast[c]) mpol[c] = cand;
            mlast[c] = cand; mcok[c] = 1;
          end
          mseen[c] = 1; mhi[c] = 1; mlo[c] = 0;
        end else if (mq[c]) mhi[c] = sat(mhi[c] + 1, PSAT);
        else mlo[c] = sat(mlo[c] + 1, PSAT);
        md[c] = mq[c]; mq[c] = ins[c];
      end
      // line
      if (hl) begin
        if (hSeen) begin
          hPer = hCnt;
          hOk = (hCnt >= H_MIN && hCnt <= H_MAX);
          if (hIdx == H_AVG - 1) begin h16Per = h16Cnt; h16Cnt = 1; hIdx = 0; end
          else begin hIdx++; h16Cnt = sat(h16Cnt + 1, H16SAT); end
        end else begin h16Cnt = 1; hIdx = 0; end
        hCnt = 1; hSeen = 1;
      end else begin
        if (hCnt > H_MAX) hOk = 0;
        hCnt = sat(hCnt + 1, HSAT);
        h16Cnt = sat(h16Cnt + 1, H16SAT);
      end
      // frame lines (uses old vSeen)
      if (vl) begin
        if (vSeen) vLin = sat(vLc + hl, LSAT);
        vLc = 0;
        if (!vSeen) begin v2c = 0; vHalf = 0; end
        else if (vHalf) begin v2Lin = sat(v2c + hl, LSAT); v2c = 0; vHalf = 0; end
        else begin v2c = sat(v2c + hl, LSAT); vHalf = 1; end
      end else begin
        vLc = sat(vLc + hl, LSAT);
        v2c = sat(v2c + hl, LSAT);
      end
      // frame clocks
      if (vl) begin
        if (vSeen) begin vPer = vCnt; vOk = (vCnt >= V_MIN && vCnt <= V_MAX); end
        vCnt = 1; vSeen = 1;
      end else begin
        if (vCnt > V_MAX) vOk = 0;
        vCnt = sat(vCnt + 1, VSAT);
      end
      // field lines
      if (fl) begin
        if (fSeen) fLin = sat(fLc + hl, LSAT);
        fLc = 0; fSeen = 1;
      end else fLc = sat(fLc + hl, LSAT);
    end
  end

  // ---------------- stimulus generator ----------------
  int hPerS = 40, hW = 4, hAct = 0, hRun = 1;
  int vPerS = 1200, vW = 80, vAct = 0;
  int fPerS = 2400, fW = 80, fAct = 0, fRun = 1;
  int hp = 0, vp = 0, fp = 0;
  int forceAddr = -1;
  int sweep = 0;
  int cyc = 0;

  function automatic string tagOf(input int a);
    case (a)
      0: return "R1 R8 R9 status";
      1: return "R3 hPeriod";
      2: return "R4 h16";
      3: return "R2 R5 vLines";
      4: return "R5 v2Lines";
      5: return "R6 fLines";
      6: return "R7 vPeriod";
      default: return "R13 unmapped";
    endcase
  endfunction

  int lastAddr = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 3 && !done) begin
      chk(tagOf(lastAddr), rdData, expRd);
      chk("R10 R11 refLost", refLost, !(hOk && vOk));
    end
    if (hp >= hPerS) hp = 0;
    if (vp >= vPerS) vp = 0;
    if (fp >= fPerS) fp = 0;
    hsIn <= hRun ? ((hp < hW) ? hAct[0] : !hAct[0]) : !hAct[0];
    vsIn <= (vp < vW) ? vAct[0] : !vAct[0];
    fsIn <= fRun ? ((fp < fW) ? fAct[0] : !fAct[0]) : !fAct[0];
    hp++; vp++; fp++;
    lastAddr = (forceAddr >= 0) ? forceAddr : sweep;
    rdAddr <= 3'(lastAddr);
    sweep = (sweep + 1) % 8;
  end

  task automatic readChk(input int a, input longint exp, input string tag);
    @(posedge clk);
    forceAddr = a;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(tag, rdData, exp);
    forceAddr = -1;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 reset refLost", refLost, 1);
    readChk(0, 0, "R1 R10 reset status");

    // phase A: active-low line 40 / frame 1200 / field 2400
    waitCyc(8000);
    readChk(0, 3, "R1 R8 R9 status active-low");
    readChk(1, 40, "R3 line period");
    readChk(2, 640, "R4 sixteen-line clocks");
    readChk(3, 30, "R5 lines per frame");
    readChk(4, 60, "R5 lines per two frames");
    readChk(5, 60, "R6 lines per field");
    readChk(6, 1200, "R7 frame clocks");
    readChk(7, 0, "R13 unmapped address");
    chk("R10 refLost valid", refLost, 0);

    // phase B: active-high pulses
    @(posedge clk);
    hPerS = 25; hW = 3; hAct = 1;
    vPerS = 800; vW = 50; vAct = 1;
    fPerS = 1600; fW = 50; fAct = 1;
    waitCyc(10000);
    readChk(0, 59, "R1 R2 status active-high");
    readChk(1, 25, "R2 R3 line period");
    readChk(2, 400, "R4 sixteen-line clocks");
    readChk(3, 32, "R2 R5 lines per frame");
    readChk(5, 64, "R6 lines per field");

    // phase C: line period too long, counter saturates
    @(posedge clk);
    hPerS = 70;
    waitCyc(3000);
    readChk(0, 58, "R8 line invalid");
    readChk(1, HSAT, "R11 saturated line period");
    chk("R10 refLost line invalid", refLost, 1);

    // phase D: line input stuck
    @(posedge clk);
    hRun = 0;
    waitCyc(3000);
    readChk(0, 58, "R11 missing line edge");
    readChk(1, HSAT, "R12 line period held");
    chk("R11 refLost no line", refLost, 1);

    // phase E: short line, long frame
    @(posedge clk);
    hRun = 1; hPerS = 15;
    vPerS = 4000; fPerS = 8000;
    waitCyc(20000);
    readChk(0, 56, "R8 R9 both invalid");
    readChk(6, 4000, "R7 long frame clocks");
    readChk(3, LSAT, "R11 saturated lines");
    readChk(5, LSAT, "R11 saturated field lines");

    // phase F: valid again, field input idle
    @(posedge clk);
    hPerS = 25; vPerS = 800; fRun = 0;
    waitCyc(6000);
    readChk(0, 59, "R8 R9 recovered");
    chk("R10 refLost ignores field", refLost, 0);
    readChk(5, LSAT, "R12 field lines held");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule